// File: doc/BRIEF.md
# SDRAM Periodic Refresh Scheduler

This block sits beside an SDRAM command controller and keeps the memory's refresh rate on schedule. A free-running cycle counter produces one refresh credit per refresh interval (for a 64 ms retention period split over 4096 refreshes, about 15.6 µs, or 1950 cycles at 125 MHz). Credits accumulate in a small capped backlog. While the backlog is non-empty the block raises a bus request. The main controller may postpone service, and the block flags the request as urgent once the backlog is full.

When the controller grants the bus, the scheduler drives the command lines itself. If the controller reports any bank open, the block first issues a precharge of all banks and waits the row-precharge time. It then issues an auto-refresh and holds the bus for the refresh cycle time before handing it back. The memory generates the refresh row and bank internally, so no address is driven. All timing values are parameters in clock cycles.

Top module: `refresh_sched`

## Requirements
- R1: During and right after reset, `req`, `urgent`, `busy` and `cmd_vld` are all low.
- R2: After reset is released, the first `req` is visible exactly REF_INTERVAL+1 cycles later. A new refresh credit arrives every REF_INTERVAL cycles, so with `grant` held high and no bank open, successive auto-refresh commands are exactly REF_INTERVAL cycles apart.
- R3: When `grant` is sampled high while `req` is high and `banks_open` is low, the next cycle carries the auto-refresh command, `busy` is high and `req` is low.
- R4: When `grant` is sampled high while `req` and `banks_open` are high, the next cycle carries a precharge-all command. It is encoded as `cmd_rcw`={ras_n,cas_n,we_n}=3'b010 with `cmd_a10`=1. The auto-refresh follows exactly T_RP cycles after it.
- R5: After an auto-refresh, `busy` stays high with no command for T_RC-1 cycles and is low exactly T_RC cycles after the refresh cycle.
- R6: `cmd_vld` is only ever high while `busy` is high, and `req` and `busy` are never high together.
- R7: While `grant` is low, `req` stays high, no command is issued and `busy` stays low, however many intervals pass.
- R8: The backlog saturates at BACKLOG_CAP credits. Credits arriving beyond the cap are dropped, so a long deferral is followed by exactly BACKLOG_CAP refreshes.
- R9: `urgent` is high exactly when the backlog holds at least URGENT_LEVEL credits. It falls in the cycle after the refresh that takes the backlog below that level.
- R10: `grant` while `req` is low has no effect: `busy` and `cmd_vld` stay low.
- R11: An auto-refresh is encoded as `cmd_rcw`=3'b001 with `cmd_a10`=0. When no command is driven, `cmd_rcw` is 3'b111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| grant | input | 1 | Bus granted to the scheduler by the main controller |
| banks_open | input | 1 | At least one bank currently has an open row |
| req | output | 1 | Refresh wanted, bus requested |
| urgent | output | 1 | Backlog full, refresh must not be postponed further |
| busy | output | 1 | Scheduler owns the command bus |
| cmd_vld | output | 1 | A command is driven this cycle |
| cmd_rcw | output | 3 | Command code {ras_n, cas_n, we_n} |
| cmd_a10 | output | 1 | Address bit 10 (high selects all banks on precharge) |

## Verification
The hardest condition to reach is a saturated backlog drained under a known credit phase. The drain must show exactly the cap number of refreshes, and no fresh credit may land in the middle of it. The bench learns the credit phase from the first request after an idle period. It then withholds the grant for ten intervals and samples `urgent` just after the seventh and eighth credits to hit the threshold exactly. It grants one cycle after a credit, so that the whole drain completes before the next credit arrives.

// File: rtl/rs_pkg.sv
// Shared types and command codes for the refresh scheduler.
// Assumes command codes are {ras_n, cas_n, we_n}, with chip select handled outside.
package rs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_PRE,
        ST_PWAIT,
        ST_REF,
        ST_RWAIT
    } rs_state_t;

    localparam logic [2:0] RCW_PREALL = 3'b010;
    localparam logic [2:0] RCW_AREF   = 3'b001;
    localparam logic [2:0] RCW_NOP    = 3'b111;

endpackage

// File: rtl/rs_interval.sv
// Free-running interval counter: pulses tick once every INTERVAL cycles.
// Assumes INTERVAL >= 2.
module rs_interval #(
    parameter int INTERVAL = 1950
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = $clog2(INTERVAL);

    logic [CW-1:0] cnt;

    assign tick = (cnt == CW'(INTERVAL - 1));

    // Count cycles and wrap at the end of each interval.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/rs_backlog.sv
// Capped counter of owed refreshes: add on each interval tick, take on each
// issued refresh. Saturates at CAP; a tick at the cap is lost.
// Assumes 1 <= URGENT_AT <= CAP.
module rs_backlog #(
    parameter int CAP       = 8,
    parameter int URGENT_AT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic add,
    input  logic take,
    output logic pending,
    output logic urgent
);
    localparam int CW = $clog2(CAP + 1);

    logic [CW-1:0] cnt;

    assign pending = (cnt != '0);
    assign urgent  = (cnt >= CW'(URGENT_AT));

    // Track owed refreshes with saturation at both ends.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (add && !take && cnt != CW'(CAP))
            cnt <= cnt + 1'b1;
        else if (take && !add && cnt != '0)
            cnt <= cnt - 1'b1;
    end
endmodule

// File: rtl/rs_sequencer.sv
// Bus sequencer: requests the bus while refreshes are owed, then on grant
// issues an optional precharge-all, waits TRP, issues auto-refresh and waits TRC.
// Assumes TRP >= 2 and TRC >= 2, and that the controller keeps off the bus while busy.
module rs_sequencer
    import rs_pkg::*;
#(
    parameter int TRP = 3,
    parameter int TRC = 9
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pending,
    input  logic       grant,
    input  logic       banks_open,
    output logic       req,
    output logic       busy,
    output logic       cmd_vld,
    output logic [2:0] cmd_rcw,
    output logic       cmd_a10,
    output logic       issued
);
    localparam int WMAX = (TRC > TRP) ? TRC : TRP;
    localparam int WW   = $clog2(WMAX) + 1;

    rs_state_t     state, nxt;
    logic [WW-1:0] wcnt;

    // Next-state selection.
    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE:  if (pending) nxt = ST_REQ;
            ST_REQ:   if (grant) nxt = banks_open ? ST_PRE : ST_REF;
            ST_PRE:   nxt = ST_PWAIT;
            ST_PWAIT: if (wcnt == '0) nxt = ST_REF;
            ST_REF:   nxt = ST_RWAIT;
            ST_RWAIT: if (wcnt == '0) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    // Wait timer loaded at each command, counted down in the wait states.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wcnt <= '0;
        else if (state == ST_PRE)
            wcnt <= WW'(TRP - 2);
        else if (state == ST_REF)
            wcnt <= WW'(TRC - 2);
        else if (wcnt != '0)
            wcnt <= wcnt - 1'b1;
    end

    // Moore outputs decoded from the state register.
    always_comb begin
        req     = (state == ST_REQ);
        busy    = (state == ST_PRE) || (state == ST_PWAIT) ||
                  (state == ST_REF) || (state == ST_RWAIT);
        cmd_vld = (state == ST_PRE) || (state == ST_REF);
        cmd_a10 = (state == ST_PRE);
        issued  = (state == ST_REF);
        if (state == ST_PRE)
            cmd_rcw = RCW_PREALL;
        else if (state == ST_REF)
            cmd_rcw = RCW_AREF;
        else
            cmd_rcw = RCW_NOP;
    end
endmodule

// File: rtl/refresh_sched.sv
// Periodic refresh scheduler top: interval counter, capped backlog and bus
// sequencer. All times in clock cycles. Assumes a synchronous active-low reset.
module refresh_sched #(
    parameter int REF_INTERVAL = 1950,
    parameter int T_RC         = 9,
    parameter int T_RP         = 3,
    parameter int BACKLOG_CAP  = 8,
    parameter int URGENT_LEVEL = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       grant,
    input  logic       banks_open,
    output logic       req,
    output logic       urgent,
    output logic       busy,
    output logic       cmd_vld,
    output logic [2:0] cmd_rcw,
    output logic       cmd_a10
);
    logic tick;
    logic pending;
    logic issued;

    rs_interval #(.INTERVAL(REF_INTERVAL)) u_interval (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    rs_backlog #(.CAP(BACKLOG_CAP), .URGENT_AT(URGENT_LEVEL)) u_backlog (
        .clk     (clk),
        .rst_n   (rst_n),
        .add     (tick),
        .take    (issued),
        .pending (pending),
        .urgent  (urgent)
    );

    rs_sequencer #(.TRP(T_RP), .TRC(T_RC)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .pending    (pending),
        .grant      (grant),
        .banks_open (banks_open),
        .req        (req),
        .busy       (busy),
        .cmd_vld    (cmd_vld),
        .cmd_rcw    (cmd_rcw),
        .cmd_a10    (cmd_a10),
        .issued     (issued)
    );
endmodule

// File: rtl/rs_checker.sv
// Protocol checker for refresh_sched, attached by bind below.
module rs_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       grant,
    input logic       banks_open,
    input logic       req,
    input logic       urgent,
    input logic       busy,
    input logic       cmd_vld,
    input logic [2:0] cmd_rcw,
    input logic       cmd_a10
);
    AST_CMD_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_vld |-> busy); // R6

    AST_REQ_BUSY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req, busy})); // R6

    AST_GRANT_CLOSED_REF: assert property (@(posedge clk) disable iff (!rst_n)
        (req && grant && !banks_open) |=> (cmd_vld && cmd_rcw == 3'b001)); // R3

    AST_GRANT_OPEN_PRE: assert property (@(posedge clk) disable iff (!rst_n)
        (req && grant && banks_open) |=> (cmd_vld && cmd_rcw == 3'b010 && cmd_a10)); // R4

    AST_PRE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld && cmd_rcw == 3'b010) |=> (!cmd_vld && busy)); // R4

    AST_REF_A10_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld && cmd_rcw == 3'b001) |-> !cmd_a10); // R11

    AST_REF_HOLDS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld && cmd_rcw == 3'b001) |=> (busy && !cmd_vld)); // R5

    AST_NO_GRANT_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !grant) |=> !busy); // R7

    AST_URGENT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(urgent) |-> $past(cmd_vld && cmd_rcw == 3'b001)); // R9
endmodule

bind refresh_sched rs_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .grant      (grant),
    .banks_open (banks_open),
    .req        (req),
    .urgent     (urgent),
    .busy       (busy),
    .cmd_vld    (cmd_vld),
    .cmd_rcw    (cmd_rcw),
    .cmd_a10    (cmd_a10)
);

// File: tb/sim_refresh_sched.sv
module sim_refresh_sched;
    localparam int IV  = 100;
    localparam int RC  = 9;
    localparam int RP  = 3;
    localparam int CAP = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       grant = 1'b0;
    logic       banks_open = 1'b0;
    logic       req, urgent, busy, cmd_vld, cmd_a10;
    logic [2:0] cmd_rcw;

    int cyc = 0;
    int checks = 0;
    int fails = 0;

    refresh_sched #(
        .REF_INTERVAL(IV), .T_RC(RC), .T_RP(RP),
        .BACKLOG_CAP(CAP), .URGENT_LEVEL(CAP)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .grant(grant), .banks_open(banks_open),
        .req(req), .urgent(urgent), .busy(busy), .cmd_vld(cmd_vld),
        .cmd_rcw(cmd_rcw), .cmd_a10(cmd_a10)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check_eq(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_req(output int at);
        at = -1;
        for (int i = 0; i < 3 * IV; i++) begin
            @(negedge clk);
            if (req) begin
                at = cyc;
                break;
            end
        end
    endtask

    task automatic wait_cmd(output int at);
        at = -1;
        for (int i = 0; i < 3 * IV; i++) begin
            @(negedge clk);
            if (cmd_vld) begin
                at = cyc;
                break;
            end
        end
    endtask

    task automatic wait_idle(output int n, output int cmds);
        n = 0;
        cmds = 0;
        do begin
            @(negedge clk);
            n++;
            if (cmd_vld) cmds++;
        end while (busy && n < 4 * RC);
    endtask

    // R1, R10, R2: reset state, stray grant, first request time.
    task automatic t_reset();
        int c0, bad, t;
        repeat (3) @(negedge clk);
        check_eq("R1 req in reset", req, 0);
        check_eq("R1 urgent in reset", urgent, 0);
        check_eq("R1 busy in reset", busy, 0);
        check_eq("R1 cmd_vld in reset", cmd_vld, 0);
        rst_n = 1'b1;
        c0 = cyc;
        grant = 1'b1;
        bad = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (busy || cmd_vld) bad++;
        end
        check_eq("R10 grant without req ignored", bad, 0);
        grant = 1'b0;
        wait_req(t);
        check_eq("R2 first req delay", t - c0, IV + 1);
    endtask

    // R3, R11, R5: refresh with all banks closed.
    task automatic t_closed();
        int t, tref, n, cmds;
        if (!req) wait_req(t);
        grant = 1'b1;
        @(negedge clk);
        tref = cyc;
        check_eq("R3 refresh next cycle", cmd_vld, 1);
        check_eq("R11 refresh code", cmd_rcw, 3'b001);
        check_eq("R11 refresh a10", cmd_a10, 0);
        check_eq("R3 busy with refresh", busy, 1);
        check_eq("R3 req dropped", req, 0);
        wait_idle(n, cmds);
        check_eq("R5 busy length after refresh", cyc - tref, RC);
        check_eq("R5 no command during tRC", cmds, 0);
        grant = 1'b0;
    endtask

    // R4: precharge-all before refresh when a bank is open.
    task automatic t_open();
        int t, tpre, tref, n, cmds;
        banks_open = 1'b1;
        wait_req(t);
        grant = 1'b1;
        @(negedge clk);
        tpre = cyc;
        check_eq("R4 precharge issued", cmd_vld, 1);
        check_eq("R4 precharge code", cmd_rcw, 3'b010);
        check_eq("R4 precharge a10", cmd_a10, 1);
        wait_cmd(tref);
        check_eq("R4 tRP gap", tref - tpre, RP);
        check_eq("R4 refresh follows", cmd_rcw, 3'b001);
        wait_idle(n, cmds);
        check_eq("R5 busy after refresh", cyc - tref, RC);
        grant = 1'b0;
        banks_open = 1'b0;
    endtask

    // R2: refresh spacing under a permanent grant.
    task automatic t_interval();
        int a, b, c, n, cmds;
        grant = 1'b1;
        wait_cmd(a);
        wait_cmd(b);
        wait_cmd(c);
        check_eq("R2 spacing first", b - a, IV);
        check_eq("R2 spacing second", c - b, IV);
        check_eq("R2 refresh code in steady state", cmd_rcw, 3'b001);
        grant = 1'b0;
        wait_idle(n, cmds);
    endtask

    // R7, R9, R8: long deferral, urgent threshold, capped drain.
    task automatic t_defer();
        int tq, bad, lost, refs, other, first_urg, after_urg;
        grant = 1'b0;
        wait_req(tq);
        check_eq("R9 urgent low at one credit", urgent, 0);
        bad = 0;
        lost = 0;
        while (cyc < tq + 10 * IV + 1) begin
            @(negedge clk);
            if (cmd_vld || busy) bad++;
            if (!req) lost++;
            if (cyc == tq + 6 * IV + 1) check_eq("R9 urgent low at seven", urgent, 0);
            if (cyc == tq + 7 * IV + 1) check_eq("R9 urgent high at eight", urgent, 1);
        end
        check_eq("R7 no command while deferred", bad, 0);
        check_eq("R7 req held while deferred", lost, 0);
        check_eq("R9 urgent still high", urgent, 1);
        grant = 1'b1;
        refs = 0;
        other = 0;
        first_urg = -1;
        after_urg = -1;
        for (int i = 0; i < 95; i++) begin
            @(negedge clk);
            if (i == 1) after_urg = urgent;
            if (cmd_vld) begin
                if (cmd_rcw == 3'b001) refs++;
                else other++;
                if (refs == 1 && first_urg < 0) first_urg = urgent;
            end
        end
        check_eq("R8 refreshes after saturation", refs, CAP);
        check_eq("R8 no other commands", other, 0);
        check_eq("R9 urgent during first refresh", first_urg, 1);
        check_eq("R9 urgent after first refresh", after_urg, 0);
        check_eq("R8 drained req", req, 0);
        check_eq("R8 drained busy", busy, 0);
        grant = 1'b0;
    endtask

    initial begin
        t_reset();
        t_closed();
        t_open();
        t_interval();
        t_defer();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 8);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule